// File: doc/BRIEF.md
# Priority Interrupt Controller with In-Service Tracking

This block collects a parameterised set of level-sensitive interrupt request lines and presents at most one of them to a single CPU port. Each line can be masked. Among the unmasked lines that are not already being serviced, the lowest-numbered one wins. The block raises its CPU request only when that winner outranks every handler already in progress. Progress is tracked by an in-service register that holds one bit per line. The CPU drives a one-cycle acknowledge pulse to collect the line number on the vector output. It later closes the handler with an end-of-interrupt command. That command either names a line or implicitly targets the most urgent handler in service.

Each line is configured in one of two modes:

- **Handshake mode:** the in-service bit is set when the CPU acknowledges the line, and only an end-of-interrupt clears it. The peripheral is acknowledged as soon as its request first reaches the CPU port.
- **Legacy mode:** the line never occupies the in-service register. Its peripheral is acknowledged only after the CPU has acknowledged it.

The mask and mode registers load as whole words through write strobes.

Top module: `isr_intc`

## Requirements
- R1: Reset is synchronous and active-low. While it is held, and on the first cycle after it is released, the outputs are as follows: `cpu_req` is 0, `dev_ack` is all zeros and `cpu_vector` is 0. The reset state also sets every mask bit (every line masked), clears the in-service register and puts every line in handshake mode (mode bit 1).
- R2: `cpu_req` is registered. One cycle after a line qualifies, `cpu_req` is 1 and the qualifying line is the lowest-numbered line that is:
  - requesting;
  - unmasked;
  - not in service.

  Line 0 has the highest priority.
- R3: A line whose mask bit is 1 is never forwarded. A mask word written with `cfg_mask_we` filters requests from the cycle after the write.
- R4: A line is forwarded only if its number is strictly lower than the lowest-numbered set in-service bit. A line whose own in-service bit is set is never forwarded.
- R5: A `cpu_ack` pulse in a cycle where `cpu_req` is 1 loads the forwarded line number into `cpu_vector` on the next cycle. It also sets that line's in-service bit if the line is in handshake mode. A `cpu_ack` in a cycle where `cpu_req` is 0 is ignored, and `cpu_vector` keeps its value.
- R6: An end-of-interrupt with `eoi_specific` = 0 clears the lowest-numbered set in-service bit. With an empty in-service register it has no effect.
- R7: An end-of-interrupt with `eoi_specific` = 1 clears exactly the bit numbered by `eoi_line`. If that bit is already clear, it has no effect.
- R8: A line whose mode bit is 0 (legacy) never sets an in-service bit. Its `dev_ack` bit pulses for one cycle, in the cycle after the CPU acknowledge.
- R9: For a line in handshake mode, its `dev_ack` bit pulses for one cycle, in the same cycle that `cpu_req` first presents that line.
- R10: When an end-of-interrupt and an accepted acknowledge fall in the same cycle, the clear is applied before the set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | Level request from each peripheral |
| cfg_mask_we | input | 1 | Load strobe for the mask word |
| cfg_mask_val | input | NUM_LINES | New mask word, 1 = line masked |
| cfg_mode_we | input | 1 | Load strobe for the mode word |
| cfg_mode_val | input | NUM_LINES | New mode word, 1 = handshake mode, 0 = legacy |
| cpu_ack | input | 1 | One-cycle acknowledge from the CPU |
| eoi_valid | input | 1 | End-of-interrupt command strobe |
| eoi_specific | input | 1 | 1 = clear the line in `eoi_line`, 0 = clear the most urgent in-service bit |
| eoi_line | input | LINE_W | Line named by an end-of-interrupt that names a line |
| cpu_req | output | 1 | Interrupt request to the CPU |
| cpu_vector | output | LINE_W | Line number captured on the last accepted acknowledge |
| dev_ack | output | NUM_LINES | One-cycle acknowledge pulse to each peripheral |

## Verification
The assertions check the following on every cycle:

- `cpu_req` never coexists with an in-service bit at or above the forwarded line's priority.
- An unaccepted acknowledge leaves `cpu_vector` unchanged.
- A legacy `dev_ack` always follows an accepted acknowledge.
- An end-of-interrupt that does not name a line removes exactly one bit when it has something to remove.
- An end-of-interrupt that names an idle line changes nothing.

The in-service register is not visible at the ports. Which bit a command cleared, and the clear-before-set order, can therefore only be shown by the bench. It does this through scenarios where the wrong bit or the wrong order changes which line is forwarded next. It also compares the outputs against a reference model under random request, mask, mode and command traffic.

// File: rtl/isr_intc_pkg.sv
// Shared definitions for the in-service interrupt controller.
// Assumes: nothing beyond IEEE 1800-2017.
package isr_intc_pkg;

    // Kind of end-of-interrupt command as seen on the eoi_specific pin.
    typedef enum logic {
        EOI_TOP   = 1'b0,   // clear most urgent in-service bit
        EOI_NAMED = 1'b1    // clear the bit named by the command
    } eoi_kind_e;

endpackage

// File: rtl/intc_first_set.sv
// Finds the lowest-numbered set bit of a vector (highest priority).
// Assumes: idx is 0 when no bit is set; callers qualify with found.
module intc_first_set #(
    parameter int W     = 8,
    parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so the lowest set index is kept last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/intc_cfg.sv
// Holds the per-line mask and mode words, loaded as whole words.
// Assumes: reset masks every line and puts every line in handshake mode.
module intc_cfg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic [N-1:0] mask_val,
    input  logic         mode_we,
    input  logic [N-1:0] mode_val,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] mode_q
);

    // Mask and mode registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            mode_q <= '1;
        end else begin
            if (mask_we) mask_q <= mask_val;
            if (mode_we) mode_q <= mode_val;
        end
    end

    // R1
    cfg_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '1 && mode_q == '1));

    // R3
    cfg_mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q));

endmodule

// File: rtl/intc_isr.sv
// In-service register: one bit per line with a handler in progress.
// Applies the end-of-interrupt clear first, then the acknowledge set.
// Assumes: set_en is only raised for lines in handshake mode.
module intc_isr
    import isr_intc_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoi_valid,
    input  eoi_kind_e        eoi_kind,
    input  logic [IDX_W-1:0] eoi_line,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_line,
    output logic [N-1:0]     isr_q,
    output logic [N-1:0]     isr_nxt
);

    logic             top_found;
    logic [IDX_W-1:0] top_idx;
    logic [N-1:0]     clr_vec;
    logic [N-1:0]     set_vec;

    intc_first_set #(.W(N), .IDX_W(IDX_W)) i_top (
        .vec   (isr_q),
        .found (top_found),
        .idx   (top_idx)
    );

    // Decode the end-of-interrupt and acknowledge into bit vectors.
    always_comb begin
        clr_vec = '0;
        set_vec = '0;
        if (eoi_valid) begin
            if (eoi_kind == EOI_NAMED) clr_vec[eoi_line] = 1'b1;
            else if (top_found)        clr_vec[top_idx]  = 1'b1;
        end
        if (set_en) set_vec[set_line] = 1'b1;
        isr_nxt = (isr_q & ~clr_vec) | set_vec;
    end

    // In-service state register.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= isr_nxt;
    end

    // R1
    isr_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (isr_q == '0));

    // R6
    isr_top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && eoi_kind == EOI_TOP && isr_q != '0 && !set_en)
        |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

    // R7
    isr_named_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && eoi_kind == EOI_NAMED && !isr_q[eoi_line] && !set_en)
        |=> $stable(isr_q));

endmodule

// File: rtl/isr_intc.sv
// Interrupt controller top.
// Masks the request lines, blocks lines already in service, and picks
// the lowest-numbered survivor. It forwards that line to the CPU only
// when it outranks every in-service line. It also drives the peripheral
// acknowledges according to each line's mode.
// Assumes: cpu_ack is a one-cycle pulse; mode 1 = handshake, 0 = legacy.
module isr_intc
    import isr_intc_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 cfg_mask_we,
    input  logic [NUM_LINES-1:0] cfg_mask_val,
    input  logic                 cfg_mode_we,
    input  logic [NUM_LINES-1:0] cfg_mode_val,
    input  logic                 cpu_ack,
    input  logic                 eoi_valid,
    input  logic                 eoi_specific,
    input  logic [LINE_W-1:0]    eoi_line,
    output logic                 cpu_req,
    output logic [LINE_W-1:0]    cpu_vector,
    output logic [NUM_LINES-1:0] dev_ack
);

    localparam int N = NUM_LINES;

    logic [N-1:0]      mask_q;
    logic [N-1:0]      mode_q;
    logic [N-1:0]      isr_q;
    logic [N-1:0]      isr_nxt;
    logic [N-1:0]      elig;
    logic [N-1:0]      dack_nxt;
    logic              best_found;
    logic [LINE_W-1:0] best_idx;
    logic              svc_found;
    logic [LINE_W-1:0] svc_idx;
    logic              fwd;
    logic              ack_take;
    logic [LINE_W-1:0] line_q;
    eoi_kind_e         eoi_kind;

    intc_cfg #(.N(N)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_we  (cfg_mask_we),
        .mask_val (cfg_mask_val),
        .mode_we  (cfg_mode_we),
        .mode_val (cfg_mode_val),
        .mask_q   (mask_q),
        .mode_q   (mode_q)
    );

    // An acknowledge counts only while a request is being presented.
    assign ack_take = cpu_ack && cpu_req;
    assign eoi_kind = eoi_kind_e'(eoi_specific);

    intc_isr #(.N(N), .IDX_W(LINE_W)) i_isr (
        .clk       (clk),
        .rst_n     (rst_n),
        .eoi_valid (eoi_valid),
        .eoi_kind  (eoi_kind),
        .eoi_line  (eoi_line),
        .set_en    (ack_take && mode_q[line_q]),
        .set_line  (line_q),
        .isr_q     (isr_q),
        .isr_nxt   (isr_nxt)
    );

    // Candidates: requesting, unmasked, not in service after this cycle.
    assign elig = irq_in & ~mask_q & ~isr_nxt;

    intc_first_set #(.W(N), .IDX_W(LINE_W)) i_best (
        .vec   (elig),
        .found (best_found),
        .idx   (best_idx)
    );

    intc_first_set #(.W(N), .IDX_W(LINE_W)) i_svc (
        .vec   (isr_nxt),
        .found (svc_found),
        .idx   (svc_idx)
    );

    // Forward only when the candidate strictly outranks all in-service lines.
    assign fwd = best_found && (!svc_found || (best_idx < svc_idx));

    // Per-line peripheral acknowledge: early for handshake, late for legacy.
    for (genvar k = 0; k < N; k++) begin : g_dack
        assign dack_nxt[k] =
            (fwd && best_idx == LINE_W'(k) && mode_q[k]
                 && !(cpu_req && line_q == LINE_W'(k)))
         || (ack_take && line_q == LINE_W'(k) && !mode_q[k]);
    end

    // Output and forwarded-line registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_req    <= 1'b0;
            line_q     <= '0;
            cpu_vector <= '0;
            dev_ack    <= '0;
        end else begin
            cpu_req <= fwd;
            line_q  <= best_idx;
            dev_ack <= dack_nxt;
            if (ack_take) cpu_vector <= line_q;
        end
    end

    // R1
    top_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!cpu_req && dev_ack == '0 && cpu_vector == '0));

    // R4
    top_outrank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> ((isr_q & ((N'(2) << line_q) - N'(1))) == '0));

    // R5
    top_vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_take |=> $stable(cpu_vector));

    // R8
    top_legacy_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_ack & ~$past(mode_q)) != '0) |-> $past(cpu_ack && cpu_req));

endmodule

// File: tb/test_isr_intc.sv
// Bench for isr_intc.
// Runs directed corner cases, then fixed-seed random traffic.
// Every cycle is compared against a reference model built from the
// requirements.
module test_isr_intc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       cfg_mask_we = 1'b0;
    logic [7:0] cfg_mask_val = '0;
    logic       cfg_mode_we = 1'b0;
    logic [7:0] cfg_mode_val = '0;
    logic       cpu_ack = 1'b0;
    logic       eoi_valid = 1'b0;
    logic       eoi_specific = 1'b0;
    logic [2:0] eoi_line = '0;
    logic       cpu_req;
    logic [2:0] cpu_vector;
    logic [7:0] dev_ack;

    int errors = 0;
    int checks = 0;
    string tag = "R1";

    // Reference model state.
    logic [7:0] m_mask, m_mode, m_isr, m_dack;
    logic       m_req;
    logic [2:0] m_line, m_vec;

    isr_intc i_isr_intc (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_in       (irq_in),
        .cfg_mask_we  (cfg_mask_we),
        .cfg_mask_val (cfg_mask_val),
        .cfg_mode_we  (cfg_mode_we),
        .cfg_mode_val (cfg_mode_val),
        .cpu_ack      (cpu_ack),
        .eoi_valid    (eoi_valid),
        .eoi_specific (eoi_specific),
        .eoi_line     (eoi_line),
        .cpu_req      (cpu_req),
        .cpu_vector   (cpu_vector),
        .dev_ack      (dev_ack)
    );

    always #4 clk = ~clk;

    function automatic int first_set(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic expect_eq(string t, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    // One clock: step the model, wait, compare all outputs, clear strobes.
    task automatic cyc();
        logic [7:0] clr, nisr, elig, ndack;
        logic       nreq, take;
        logic [2:0] nline, nvec;
        int b, t, tp;
        if (!rst_n) begin
            m_mask = '1; m_mode = '1; nisr = '0; nreq = 0;
            nline = 0; nvec = 0; ndack = '0;
        end else begin
            take = cpu_ack && m_req;
            clr = '0;
            tp = first_set(m_isr);
            if (eoi_valid) begin
                if (eoi_specific) clr[eoi_line] = 1'b1;
                else if (tp >= 0) clr[tp] = 1'b1;
            end
            nisr = m_isr & ~clr;
            if (take && m_mode[m_line]) nisr[m_line] = 1'b1;
            elig = irq_in & ~m_mask & ~nisr;
            b = first_set(elig);
            t = first_set(nisr);
            nreq = (b >= 0) && (t < 0 || b < t);
            nline = (b >= 0) ? 3'(b) : 3'd0;
            nvec = take ? m_line : m_vec;
            ndack = '0;
            if (nreq && m_mode[b] && !(m_req && m_line == 3'(b))) ndack[b] = 1'b1;
            if (take && !m_mode[m_line]) ndack[m_line] = 1'b1;
            if (cfg_mask_we) m_mask = cfg_mask_val;
            if (cfg_mode_we) m_mode = cfg_mode_val;
        end
        @(posedge clk);
        @(negedge clk);
        m_isr = nisr; m_req = nreq; m_line = nline; m_vec = nvec; m_dack = ndack;
        checks++;
        if (cpu_req !== m_req || cpu_vector !== m_vec || dev_ack !== m_dack) begin
            errors++;
            $display("FAIL %s: actual req=%0b vec=%0d ack=%02h expected req=%0b vec=%0d ack=%02h",
                     tag, cpu_req, cpu_vector, dev_ack, m_req, m_vec, m_dack);
        end
        cpu_ack = 0; eoi_valid = 0; cfg_mask_we = 0; cfg_mode_we = 0;
    endtask

    task automatic eoi(bit spec, logic [2:0] ln);
        eoi_valid = 1; eoi_specific = spec; eoi_line = ln;
    endtask

    // Watchdog: an expired run is a failed check and still reports.
    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);

        // R1: reset with all requests high
        tag = "R1"; irq_in = 8'hFF;
        cyc(); cyc();
        rst_n = 1;
        cyc();
        expect_eq("R1 cpu_req", cpu_req, 0);
        expect_eq("R1 dev_ack", dev_ack, 0);
        expect_eq("R1 vector", cpu_vector, 0);
        tag = "R3"; cyc();
        expect_eq("R3 all masked", cpu_req, 0);

        // R3/R2/R9: unmask only line 3
        cfg_mask_we = 1; cfg_mask_val = 8'hF7; cyc();
        tag = "R9"; cyc();
        expect_eq("R2 req line3", cpu_req, 1);
        expect_eq("R9 early dev_ack", dev_ack, 8'h08);
        tag = "R5"; cpu_ack = 1; cyc();
        expect_eq("R5 vector 3", cpu_vector, 3);
        expect_eq("R4 same line blocked", cpu_req, 0);

        // R2/R4: open all lines, line 0 wins, then nothing outranks 0
        tag = "R4"; cfg_mask_we = 1; cfg_mask_val = 8'h00; cyc();
        cyc();
        expect_eq("R2 req line0", cpu_req, 1);
        expect_eq("R9 dev_ack line0", dev_ack, 8'h01);
        cpu_ack = 1; cyc();
        expect_eq("R5 vector 0", cpu_vector, 0);
        expect_eq("R4 blocked by 0", cpu_req, 0);
        irq_in = 8'hFE; cyc();
        expect_eq("R4 still blocked", cpu_req, 0);

        // R6: clears line 0 only, line 1 now outranks 3
        tag = "R6"; eoi(0, 3'd0); cyc();
        expect_eq("R6 top cleared", cpu_req, 1);
        cpu_ack = 1; cyc();
        expect_eq("R5 vector 1", cpu_vector, 1);

        // R7: in service {1,3}, only line 3 requesting
        tag = "R7"; irq_in = 8'h08; eoi(1, 3'd1); cyc();
        expect_eq("R7 3 still held", cpu_req, 0);
        eoi(1, 3'd5); cyc();
        expect_eq("R7 idle named no effect", cpu_req, 0);
        eoi(1, 3'd3); cyc();
        expect_eq("R7 named cleared", cpu_req, 1);

        // R10: in service {3}, line 1 presented; ack and top EOI together
        tag = "R10"; cpu_ack = 1; cyc();
        irq_in = 8'h0A; cyc();
        expect_eq("R10 req line1", cpu_req, 1);
        cpu_ack = 1; eoi(0, 3'd0); cyc();
        expect_eq("R10 clear then set", cpu_req, 0);
        expect_eq("R10 vector 1", cpu_vector, 1);
        eoi(0, 3'd0); cyc();
        expect_eq("R10 1 released", cpu_req, 1);

        // R6: top EOI with an empty in-service register
        tag = "R6"; irq_in = 8'h00; cyc();
        eoi(0, 3'd0); cyc();
        expect_eq("R6 empty no effect", cpu_req, 0);

        // R8: line 4 legacy
        tag = "R8"; cfg_mode_we = 1; cfg_mode_val = 8'hEF; cyc();
        irq_in = 8'h10; cyc();
        expect_eq("R8 req line4", cpu_req, 1);
        expect_eq("R8 no early ack", dev_ack, 0);
        cpu_ack = 1; cyc();
        expect_eq("R8 late dev_ack", dev_ack, 8'h10);
        expect_eq("R8 vector 4", cpu_vector, 4);
        expect_eq("R8 no in-service", cpu_req, 1);
        irq_in = 8'h00; cyc();
        expect_eq("R8 drop", cpu_req, 0);

        // R5: ack without request is ignored
        tag = "R5"; cpu_ack = 1; cyc();
        expect_eq("R5 ignored ack", cpu_vector, 4);

        // Random traffic against the model (R2 R3 R4 R5 R6 R7 R8 R9 R10)
        tag = "R2 random";
        for (int i = 0; i < 4000; i++) begin
            irq_in = 8'($urandom);
            if ($urandom_range(0, 19) == 0) begin
                cfg_mask_we = 1; cfg_mask_val = 8'($urandom) & 8'($urandom);
            end
            if ($urandom_range(0, 19) == 0) begin
                cfg_mode_we = 1; cfg_mode_val = 8'($urandom) | 8'($urandom);
            end
            cpu_ack = ($urandom_range(0, 9) < 4);
            if ($urandom_range(0, 4) == 0) eoi(1'($urandom), 3'($urandom));
            cyc();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule